// File: doc/BRIEF.md
# Multiply and Divide Execution Unit

This unit carries out the integer multiply, divide and remainder operations of a processor's arithmetic group. The pipeline presents two XLEN-bit operands, a three-bit operation selector and a word flag together with a one-cycle start strobe. The unit raises busy while it works and returns its answer on `result` with a one-cycle `done` pulse. The result then holds until the next operation completes.

Multiplication forms the full double-width product in one pass. It returns the low half, or the high half with the signedness of each operand chosen by the selector. Division and remainder run on an iterative restoring shift-subtract core that retires one quotient bit per cycle. They work on operand magnitudes and fix the signs at the end, so both results are truncated toward zero. A zero divisor and the single signed overflow case (most negative value divided by minus one) give fixed results defined by the architecture. On a 64-bit build the word flag selects the 32-bit variants: these use the low 32 bits of each operand and sign-extend the 32-bit answer.

Top module: `muldiv_unit`

## Requirements
- R1: After reset, `busy`, `done` and `result` are all zero.
- R2: For `op` 000 the result is bits XLEN-1..0 of the product. For 001 it is bits 2·XLEN-1..XLEN of the product with both operands signed. For 010 it is the same high half with `opa` signed and `opb` unsigned. For 011 it is the high half with both operands unsigned.
- R3: `op` 100 returns the signed quotient, 101 the unsigned quotient, 110 the signed remainder and 111 the unsigned remainder. Quotients are truncated toward zero, and a remainder takes the sign of the dividend.
- R4: With a zero divisor, the quotient is all ones and the remainder equals the dividend, for both signed and unsigned forms.
- R5: A signed divide of the most negative value by -1 returns the most negative value as quotient and zero as remainder.
- R6: When XLEN is 64 and `word` is 1, the operations 000 and 100..111 use only bits 31..0 of each operand and return the 32-bit answer sign-extended to 64 bits.
- R7: `done` rises one cycle after the start edge for every multiply and for a divide by zero. For any other divide or remainder it rises N+1 cycles after the start edge, where N is 32 for a word variant and XLEN otherwise.
- R8: `busy` is high from the cycle after an accepted start until the completion edge. `done` is a single-cycle pulse, and `busy` is low whenever `done` is high.
- R9: A start raised while `busy` is high is ignored. The running operation keeps its result and its latency, and no extra `done` appears.
- R10: A start raised in the same cycle as a `done` pulse is accepted, so operations can run back to back.
- R11: For `op` 001..011 the `word` flag has no effect, and the full-width high half is returned.
- R12: `result` changes only on the edge that raises `done`, and holds its value otherwise.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Start strobe, sampled when idle |
| op | input | 3 | Operation selector (see R2, R3) |
| word | input | 1 | Selects the 32-bit variants on 64-bit builds |
| opa | input | XLEN | First operand (multiplicand or dividend) |
| opb | input | XLEN | Second operand (multiplier or divisor) |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle completion pulse |
| result | output | XLEN | Result of the last completed operation |

## Verification
Two events can fall in the same cycle: the completion pulse of one operation and the start strobe of the next. The bench raises `start` for a multiply in exactly the cycle where a long divide shows `done`. It then checks that the divide result is intact and that the multiply completes one cycle later with its own answer. The opposite case, a strobe raised while the divider is still iterating, is driven with conflicting operands. The bench judges it by an unchanged divide result, an unchanged latency and the absence of a second `done`.

// File: rtl/muldiv_unit.sv
module muldiv_unit #(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            start,
  input  logic [2:0]      op,
  input  logic            word,
  input  logic [XLEN-1:0] opa,
  input  logic [XLEN-1:0] opb,
  output logic            busy,
  output logic            done,
  output logic [XLEN-1:0] result
);
  localparam int SH = XLEN - 32;
  localparam int CW = $clog2(XLEN + 1);

  typedef enum logic [1:0] {S_IDLE, S_MUL, S_DIV, S_FIN} st_t;
  st_t st;

  function automatic logic [XLEN-1:0] sx32(input logic [XLEN-1:0] v);
    sx32 = XLEN'($signed(v << SH) >>> SH);
  endfunction

  function automatic logic [XLEN-1:0] zx32(input logic [XLEN-1:0] v);
    zx32 = (v << SH) >> SH;
  endfunction

  // operand preparation at the start strobe
  logic            is_div, wd, sdiv, neg_a, neg_b, dz, take;
  logic [XLEN-1:0] ax, bx, mag_a, mag_b;

  assign is_div = op[2];
  assign wd     = word && (XLEN == 64) && (op == 3'b000 || is_div);
  assign sdiv   = is_div && !op[0];
  assign ax     = wd ? (sdiv ? sx32(opa) : zx32(opa)) : opa;
  assign bx     = wd ? (sdiv ? sx32(opb) : zx32(opb)) : opb;
  assign neg_a  = sdiv && ax[XLEN-1];
  assign neg_b  = sdiv && bx[XLEN-1];
  assign mag_a  = neg_a ? -ax : ax;
  assign mag_b  = neg_b ? -bx : bx;
  assign dz     = (bx == '0);
  assign take   = start && (st == S_IDLE);

  // held state
  logic [2:0]      mop;
  logic            mwd, negq, negr;
  logic [CW-1:0]   cnt;
  logic [XLEN-1:0] ma, mb, rq, rr, dv;

  // multiplier
  logic                   sa, sb;
  logic [XLEN:0]          ea, eb;
  logic signed [2*XLEN+1:0] prod;
  logic [XLEN-1:0]        mul_out;

  assign sa      = (mop == 3'b001) || (mop == 3'b010);
  assign sb      = (mop == 3'b001);
  assign ea      = {sa & ma[XLEN-1], ma};
  assign eb      = {sb & mb[XLEN-1], mb};
  assign prod    = $signed(ea) * $signed(eb);
  assign mul_out = mwd ? sx32(prod[XLEN-1:0]) :
                   (mop == 3'b000) ? prod[XLEN-1:0] : prod[2*XLEN-1:XLEN];

  // one restoring division step
  logic [XLEN:0]   rem_sh, diff;
  logic            qbit;
  logic [XLEN-1:0] step_r;

  assign rem_sh = {rr, rq[XLEN-1]};
  assign diff   = rem_sh - {1'b0, dv};
  assign qbit   = !diff[XLEN];
  assign step_r = qbit ? diff[XLEN-1:0] : rem_sh[XLEN-1:0];

  // sign fix and selection
  logic [XLEN-1:0] qv, qs, rs, sel, fin_out;

  assign qv      = mwd ? zx32(rq) : rq;
  assign qs      = negq ? -qv : qv;
  assign rs      = negr ? -rr : rr;
  assign sel     = mop[1] ? rs : qs;
  assign fin_out = mwd ? sx32(sel) : sel;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st <= S_IDLE; busy <= 1'b0; done <= 1'b0; result <= '0;
      mop <= '0; mwd <= 1'b0; negq <= 1'b0; negr <= 1'b0; cnt <= '0;
      ma <= '0; mb <= '0; rq <= '0; rr <= '0; dv <= '0;
    end else begin
      done <= 1'b0;
      case (st)
        S_IDLE: if (take) begin
          mop  <= op;
          mwd  <= wd;
          busy <= 1'b1;
          if (!is_div) begin
            ma <= opa; mb <= opb; st <= S_MUL;
          end else if (dz) begin
            rq <= '1; rr <= ax; negq <= 1'b0; negr <= 1'b0; st <= S_FIN;
          end else begin
            rq   <= mag_a << (wd ? SH : 0);
            rr   <= '0;
            dv   <= mag_b;
            negq <= neg_a ^ neg_b;
            negr <= neg_a;
            cnt  <= wd ? CW'(32) : CW'(XLEN);
            st   <= S_DIV;
          end
        end
        S_MUL: begin
          result <= mul_out; done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
        end
        S_DIV: begin
          rr  <= step_r;
          rq  <= {rq[XLEN-2:0], qbit};
          cnt <= cnt - 1'b1;
          if (cnt == CW'(1)) st <= S_FIN;
        end
        S_FIN: begin
          result <= fin_out; done <= 1'b1; busy <= 1'b0; st <= S_IDLE;
        end
        default: st <= S_IDLE;
      endcase
    end
  end

  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R8
  AST_DONE_NOT_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy); // R8
  AST_START_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy) |=> busy); // R8
  AST_MUL_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    (start && !busy && !op[2]) |=> ##1 done); // R7
  AST_IDLE_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |=> !done); // R9
  AST_RESULT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> done); // R12
endmodule

// File: tb/muldiv_unit_tb.sv
module muldiv_unit_tb;
  localparam int CLK_P = 10;
  localparam int XLEN  = 64;

  logic            clk = 1'b0;
  logic            rst_n = 1'b0;
  logic            start = 1'b0;
  logic [2:0]      op = '0;
  logic            word = 1'b0;
  logic [XLEN-1:0] opa = '0, opb = '0;
  logic            busy, done;
  logic [XLEN-1:0] result;

  int checks = 0;
  int errors = 0;

  muldiv_unit #(.XLEN(XLEN)) u_dut (
    .clk(clk), .rst_n(rst_n), .start(start), .op(op), .word(word),
    .opa(opa), .opb(opb), .busy(busy), .done(done), .result(result)
  );

  always #(CLK_P/2) clk = ~clk;

  localparam logic [63:0] MIN64 = 64'h8000_0000_0000_0000;
  localparam logic [63:0] NEG1  = 64'hFFFF_FFFF_FFFF_FFFF;

  task automatic chk(input string tag, input logic [63:0] got, input logic [63:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  function automatic logic [63:0] model(input logic [2:0] o, input logic w,
                                        input logic [63:0] a, input logic [63:0] b);
    logic ew;
    logic signed [129:0] pa, pb;
    logic [129:0] p;
    logic [31:0] a32, b32, q32, r32, v32;
    logic [63:0] q64, r64;
    int sa32, sb32;
    longint sa64, sb64;
    ew = w && (o == 3'b000 || o[2]);
    if (!o[2]) begin
      pa = (o == 3'b001 || o == 3'b010) ? {{66{a[63]}}, a} : {66'b0, a};
      pb = (o == 3'b001) ? {{66{b[63]}}, b} : {66'b0, b};
      p  = pa * pb;
      if (ew) return {{32{p[31]}}, p[31:0]};
      return (o == 3'b000) ? p[63:0] : p[127:64];
    end
    if (ew) begin
      a32 = a[31:0]; b32 = b[31:0];
      if (b32 == 0) begin q32 = '1; r32 = a32; end
      else if (!o[0] && a32 == 32'h8000_0000 && b32 == 32'hFFFF_FFFF) begin q32 = a32; r32 = 0; end
      else if (!o[0]) begin
        sa32 = a32; sb32 = b32; q32 = sa32 / sb32; r32 = sa32 % sb32;
      end else begin q32 = a32 / b32; r32 = a32 % b32; end
      v32 = o[1] ? r32 : q32;
      return {{32{v32[31]}}, v32};
    end
    if (b == 0) begin q64 = NEG1; r64 = a; end
    else if (!o[0] && a == MIN64 && b == NEG1) begin q64 = MIN64; r64 = 0; end
    else if (!o[0]) begin
      sa64 = a; sb64 = b; q64 = sa64 / sb64; r64 = sa64 % sb64;
    end else begin q64 = a / b; r64 = a % b; end
    return o[1] ? r64 : q64;
  endfunction

  function automatic int exp_lat(input logic [2:0] o, input logic w, input logic [63:0] b);
    logic ew;
    ew = w && (o == 3'b000 || o[2]);
    if (!o[2]) return 1;
    if (ew ? (b[31:0] == 0) : (b == 0)) return 1;
    return (ew ? 32 : 64) + 1;
  endfunction

  // drive one operation from a negedge, wait for done, check value, latency, busy
  task automatic run_op(input string tag, input logic [2:0] o, input logic w,
                        input logic [63:0] a, input logic [63:0] b);
    int lat;
    start = 1'b1; op = o; word = w; opa = a; opb = b;
    @(negedge clk);
    start = 1'b0;
    chk({tag, " R8 busy after start"}, 64'(busy), 64'd1);
    lat = 0;
    do begin
      @(negedge clk);
      lat++;
    end while (!done && lat < 200);
    chk({tag, " R7 latency"}, 64'(lat), 64'(exp_lat(o, w, b)));
    chk({tag, " R8 busy low at done"}, 64'(busy), 64'd0);
    chk(tag, result, model(o, w, a, b));
    @(negedge clk);
    chk({tag, " R8 done single pulse"}, 64'(done), 64'd0);
  endtask

  task automatic t_reset;
    chk("R1 busy", 64'(busy), 0);
    chk("R1 done", 64'(done), 0);
    chk("R1 result", result, 0);
  endtask

  task automatic t_mul;
    run_op("R2 mul low", 3'b000, 0, 64'h1234_5678_9ABC_DEF0, 64'hFEDC_BA98_7654_3210);
    run_op("R2 mulh ss", 3'b001, 0, NEG1, 64'd7);
    run_op("R2 mulh ss min", 3'b001, 0, MIN64, MIN64);
    run_op("R2 mulh su", 3'b010, 0, NEG1, NEG1);
    run_op("R2 mulh uu", 3'b011, 0, NEG1, NEG1);
    run_op("R2 mulh uu mixed", 3'b011, 0, 64'hDEAD_BEEF_0000_0001, 64'h0000_0001_0000_0003);
    run_op("R6 word mul", 3'b000, 1, 64'hAAAA_AAAA_0001_0000, 64'h5555_5555_0000_8000);
    run_op("R11 word ignored mulh", 3'b001, 1, 64'hFFFF_FFFF_0000_0000, 64'h0000_0002_0000_0005);
  endtask

  task automatic t_div;
    run_op("R3 div signed", 3'b100, 0, -64'sd7, 64'd2);
    run_op("R3 rem signed", 3'b110, 0, -64'sd7, 64'd2);
    run_op("R3 rem signed neg divisor", 3'b110, 0, 64'd7, -64'sd2);
    run_op("R3 div unsigned", 3'b101, 0, NEG1, 64'd10);
    run_op("R3 rem unsigned", 3'b111, 0, NEG1, 64'd10);
    run_op("R3 div larger divisor", 3'b100, 0, 64'd3, 64'd100);
    run_op("R6 word div signed", 3'b100, 1, 64'h1234_5678_FFFF_FF9C, 64'h0000_0000_0000_0007);
    run_op("R6 word divu", 3'b101, 1, 64'h0000_0001_FFFF_FFFE, 64'h9999_9999_0000_0003);
    run_op("R6 word remu sext", 3'b111, 1, 64'h0000_0000_FFFF_FFFF, 64'h0000_0000_8000_0001);
  endtask

  task automatic t_dz;
    run_op("R4 div by zero", 3'b100, 0, 64'd55, 64'd0);
    run_op("R4 divu by zero", 3'b101, 0, 64'd55, 64'd0);
    run_op("R4 rem by zero", 3'b110, 0, -64'sd9, 64'd0);
    run_op("R4 remu by zero", 3'b111, 0, MIN64, 64'd0);
    run_op("R4 word remu by zero", 3'b111, 1, 64'h0000_0000_8000_0000, 64'hFFFF_FFFF_0000_0000);
  endtask

  task automatic t_ovf;
    run_op("R5 overflow quotient", 3'b100, 0, MIN64, NEG1);
    run_op("R5 overflow remainder", 3'b110, 0, MIN64, NEG1);
    run_op("R5 word overflow quotient", 3'b100, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
    run_op("R5 word overflow remainder", 3'b110, 1, 64'h0000_0000_8000_0000, 64'h0000_0000_FFFF_FFFF);
  endtask

  // R9: a strobe during a running divide has no effect
  task automatic t_ignore;
    int lat;
    int extra;
    logic [63:0] e;
    e = model(3'b101, 0, 64'd1000, 64'd7);
    start = 1'b1; op = 3'b101; word = 0; opa = 64'd1000; opb = 64'd7;
    @(negedge clk);
    lat = 0;
    start = 1'b0;
    repeat (5) begin @(negedge clk); lat++; end
    start = 1'b1; op = 3'b000; opa = 64'd3; opb = 64'd3;
    @(negedge clk); lat++;
    start = 1'b0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk("R9 latency unchanged", 64'(lat), 64'd65);
    chk("R9 result kept", result, e);
    extra = 0;
    repeat (4) begin @(negedge clk); if (done) extra++; end
    chk("R9 no extra done", 64'(extra), 64'd0);
  endtask

  // R10: start in the done cycle is accepted; R12 result holds
  task automatic t_b2b;
    int lat;
    logic [63:0] e1, e2;
    e1 = model(3'b100, 0, -64'sd100, 64'd9);
    e2 = model(3'b000, 0, 64'd6, 64'd7);
    start = 1'b1; op = 3'b100; word = 0; opa = -64'sd100; opb = 64'd9;
    @(negedge clk);
    start = 1'b0;
    lat = 0;
    while (!done && lat < 200) begin @(negedge clk); lat++; end
    chk("R10 first result", result, e1);
    start = 1'b1; op = 3'b000; opa = 64'd6; opb = 64'd7;
    @(negedge clk);
    start = 1'b0;
    chk("R10 second accepted busy", 64'(busy), 64'd1);
    @(negedge clk);
    chk("R10 second done", 64'(done), 64'd1);
    chk("R10 second result", result, e2);
    opa = 64'd99; opb = 64'd99; op = 3'b011;
    repeat (6) @(negedge clk);
    chk("R12 result holds", result, e2);
  endtask

  initial begin
    #(CLK_P * 150000);
    errors++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    @(negedge clk);
    t_mul();
    t_div();
    t_dz();
    t_ovf();
    t_ignore();
    t_b2b();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule